// File: doc/BRIEF.md
# Interrupt Request Priority Resolver

This block takes eight interrupt request lines for one controller. It stores four per-line registers: pending requests, masks, in-service lines and trigger modes. Each line captures its request either from a rising transition or from a held level, and the mode is set for each line separately. Every cycle the block finds the best unmasked request under a rotating priority scheme. It raises that request only if it outranks everything already in service.

Software-style writes load the trigger, mask and in-service registers and the rotation base through plain write-enable ports. An acknowledge port marks the chosen line as in service and retires its captured edge. A nesting flag and a cascade line index let a master controller leave out its cascade line's in-service bit when it compares priority. The result is a registered pending flag and a registered 3-bit line index.

Top module: `irq_prio_resolver`

## Requirements
- R1: A line whose trigger bit is 1 (level mode) has its request bit equal to its input level as sampled on the previous clock edge. The bit sets while the input is high and clears once the input is low.
- R2: A line whose trigger bit is 0 (edge mode, the reset value) sets its request bit only when its input goes from low to high. An input that stays high after the request is acknowledged raises no new request.
- R3: In edge mode, an input that falls back low leaves the request bit set. An acknowledge of that line (ackValid with ackLine = line) clears the request bit and sets the line's in-service bit.
- R4: With rotation base b, line (b + k) mod 8 has priority k, and k = 0 is the highest. The reported line index is the line of the lowest k among the candidates.
- R5: A request whose mask bit is 1 is not a candidate. Clearing the mask bit makes the stored request visible.
- R6: A candidate is signalled only if its priority is strictly higher than the highest-priority in-service line. An equal or lower priority gives pending 0.
- R7: With nestEn high, the in-service bit of line cascadeLine is left out of the in-service priority.
- R8: irqPending and irqLine are registered. They change on the clock edge after the edge that updates the request, mask, in-service or base registers. While nothing is pending, irqLine reads 0.
- R9: A synchronous reset clears all registers, including the rotation base. Afterwards all lines are edge mode and unmasked, with nothing pending and nothing in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqLevel | input | 8 | Request input level of each line |
| trigWe | input | 1 | Load the trigger-mode register |
| trigData | input | 8 | Trigger modes, 1 = level, 0 = edge |
| maskWe | input | 1 | Load the mask register |
| maskData | input | 8 | Mask bits, 1 = masked |
| isrWe | input | 1 | Load the in-service register |
| isrData | input | 8 | In-service value |
| baseWe | input | 1 | Load the rotation base |
| baseData | input | 3 | Rotation base value |
| ackValid | input | 1 | Acknowledge the line on ackLine |
| ackLine | input | 3 | Line being acknowledged |
| nestEn | input | 1 | Leave the cascade line out of the in-service priority |
| cascadeLine | input | 3 | Index of the cascade line |
| irqPending | output | 1 | A request outranks the in-service lines |
| irqLine | output | 3 | Index of the winning line, 0 when none |

## Verification
The hardest state to reach is a set of several stored requests together with in-service bits, because edge requests must be kept while the rotation base and in-service register are rewritten around them. The stimulus gives lines 1 and 6 rising edges together and then leaves them unacknowledged. It sweeps the base, and then loads in-service values above, equal to and below the winner's priority. With a mask hiding line 1 and the cascade line in service, switching nestEn and cascadeLine then shows the exclusion rule in both directions.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LINES = 8;
  localparam int IDXW  = $clog2(LINES);
  localparam int PRIW  = IDXW + 1;

  typedef struct packed {
    logic             loadTrig;
    logic             loadMask;
    logic             loadIsr;
    logic             loadBase;
    logic [LINES-1:0] ackMask;
  } ctrlStrobes_t;

  // Rotated priority search: returns k of the best set bit, LINES if none.
  function automatic logic [PRIW-1:0] bestPrio(input logic [LINES-1:0] bits,
                                               input logic [IDXW-1:0] base);
    logic [PRIW-1:0] res;
    logic [IDXW-1:0] pos;
    res = PRIW'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      pos = base + IDXW'(k);
      if (bits[pos]) res = PRIW'(k);
    end
    return res;
  endfunction
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic            trigWe,
  input  logic            maskWe,
  input  logic            isrWe,
  input  logic            baseWe,
  input  logic            ackValid,
  input  logic [IDXW-1:0] ackLine,
  output ctrlStrobes_t    stb
);
  logic [LINES-1:0] ackDec;

  for (genvar i = 0; i < LINES; i++) begin : g_ack
    assign ackDec[i] = ackValid && (ackLine == IDXW'(i));
  end

  always_comb begin
    stb.loadTrig = trigWe;
    stb.loadMask = maskWe;
    stb.loadIsr  = isrWe;
    stb.loadBase = baseWe;
    stb.ackMask  = ackDec;
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_prio_pkg::*;
(
  input  logic [LINES-1:0] irrQ,
  input  logic [LINES-1:0] imrQ,
  input  logic [LINES-1:0] isrQ,
  input  logic [IDXW-1:0]  baseQ,
  input  logic             nestEn,
  input  logic [IDXW-1:0]  cascadeLine,
  output logic             winValid,
  output logic [IDXW-1:0]  winLine
);
  logic [LINES-1:0] cand;
  logic [LINES-1:0] isrEff;
  logic [PRIW-1:0]  candPrio;
  logic [PRIW-1:0]  curPrio;

  always_comb begin
    cand   = irrQ & ~imrQ;
    isrEff = isrQ;
    if (nestEn) isrEff[cascadeLine] = 1'b0;
    candPrio = bestPrio(cand, baseQ);
    curPrio  = bestPrio(isrEff, baseQ);
    winValid = candPrio < curPrio;
    winLine  = winValid ? (candPrio[IDXW-1:0] + baseQ) : '0;
  end
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     stb,
  input  logic [LINES-1:0] reqLevel,
  input  logic [LINES-1:0] trigData,
  input  logic [LINES-1:0] maskData,
  input  logic [LINES-1:0] isrData,
  input  logic [IDXW-1:0]  baseData,
  input  logic             nestEn,
  input  logic [IDXW-1:0]  cascadeLine,
  output logic             irqPending,
  output logic [IDXW-1:0]  irqLine
);
  logic [LINES-1:0] irrQ, imrQ, isrQ, trigQ, prevQ;
  logic [IDXW-1:0]  baseQ;
  logic [LINES-1:0] riseMask, irrNext, candNow;
  logic             winValid;
  logic [IDXW-1:0]  winLine;

  always_comb begin
    riseMask = reqLevel & ~prevQ;
    irrNext  = (trigQ & reqLevel) |
               (~trigQ & ((irrQ & ~stb.ackMask) | riseMask));
    candNow  = irrQ & ~imrQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irrQ  <= '0;
      imrQ  <= '0;
      isrQ  <= '0;
      trigQ <= '0;
      prevQ <= '0;
      baseQ <= '0;
    end else begin
      irrQ  <= irrNext;
      prevQ <= reqLevel;
      isrQ  <= (stb.loadIsr ? isrData : isrQ) | stb.ackMask;
      if (stb.loadMask) imrQ  <= maskData;
      if (stb.loadTrig) trigQ <= trigData;
      if (stb.loadBase) baseQ <= baseData;
    end
  end

  irq_prio_resolve u_resolve (
    .irrQ(irrQ), .imrQ(imrQ), .isrQ(isrQ), .baseQ(baseQ),
    .nestEn(nestEn), .cascadeLine(cascadeLine),
    .winValid(winValid), .winLine(winLine)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irqPending <= 1'b0;
      irqLine    <= '0;
    end else begin
      irqPending <= winValid;
      irqLine    <= winLine;
    end
  end

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((irrQ ^ $past(reqLevel)) & $past(trigQ)) == '0); // R1

  AST_EDGE_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (~$past(irrQ) & irrQ & ~$past(trigQ) &
                     ~($past(reqLevel) & ~$past(prevQ))) == '0); // R2

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($past(irrQ) & ~irrQ & ~$past(trigQ) &
                     ~$past(stb.ackMask)) == '0); // R3

  AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irqPending) |->
      (|($past(candNow) & (LINES'(1) << irqLine)))); // R5

  AST_WIN_NOT_SERVED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irqPending && !$past(nestEn)) |->
      !(|($past(isrQ) & (LINES'(1) << irqLine)))); // R6

  AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irqPending |-> irqLine == '0); // R8
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] reqLevel,
  input  logic             trigWe,
  input  logic [LINES-1:0] trigData,
  input  logic             maskWe,
  input  logic [LINES-1:0] maskData,
  input  logic             isrWe,
  input  logic [LINES-1:0] isrData,
  input  logic             baseWe,
  input  logic [IDXW-1:0]  baseData,
  input  logic             ackValid,
  input  logic [IDXW-1:0]  ackLine,
  input  logic             nestEn,
  input  logic [IDXW-1:0]  cascadeLine,
  output logic             irqPending,
  output logic [IDXW-1:0]  irqLine
);
  ctrlStrobes_t stb;

  irq_prio_ctrl u_ctrl (
    .trigWe(trigWe), .maskWe(maskWe), .isrWe(isrWe), .baseWe(baseWe),
    .ackValid(ackValid), .ackLine(ackLine), .stb(stb)
  );

  irq_prio_dp u_dp (
    .clk(clk), .rst(rst), .stb(stb), .reqLevel(reqLevel),
    .trigData(trigData), .maskData(maskData), .isrData(isrData),
    .baseData(baseData), .nestEn(nestEn), .cascadeLine(cascadeLine),
    .irqPending(irqPending), .irqLine(irqLine)
  );
endmodule

// File: tb/sim_irq_prio_resolver.sv
`timescale 1ns/1ps
module sim_irq_prio_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reqLevel = '0, trigData = '0, maskData = '0, isrData = '0;
  logic       trigWe = 0, maskWe = 0, isrWe = 0, baseWe = 0, ackValid = 0;
  logic [2:0] baseData = '0, ackLine = '0, cascadeLine = 3'd2;
  logic       nestEn = 0;
  logic       irqPending;
  logic [2:0] irqLine;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic pend; logic [2:0] line; string tag; } item_t;
  item_t q[$];
  event itemEv;

  always #10 clk = ~clk;

  irq_prio_resolver u0 (
    .clk(clk), .rst(rst), .reqLevel(reqLevel),
    .trigWe(trigWe), .trigData(trigData), .maskWe(maskWe), .maskData(maskData),
    .isrWe(isrWe), .isrData(isrData), .baseWe(baseWe), .baseData(baseData),
    .ackValid(ackValid), .ackLine(ackLine), .nestEn(nestEn),
    .cascadeLine(cascadeLine), .irqPending(irqPending), .irqLine(irqLine)
  );

  // Monitor: compares outputs against each queued expectation.
  initial begin
    item_t it;
    forever begin
      @(itemEv);
      while (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (irqPending !== it.pend || irqLine !== it.line) begin
          errors++;
          $display("FAIL %s: got pend=%0b line=%0d, expected pend=%0b line=%0d",
                   it.tag, irqPending, irqLine, it.pend, it.line);
        end
      end
    end
  end

  task automatic push(input logic p, input logic [2:0] l, input string t);
    item_t it;
    it.pend = p; it.line = l; it.tag = t;
    q.push_back(it);
    -> itemEv;
    #1;
  endtask

  // Expect value after the next edge (one register stage past current state).
  task automatic check(input logic p, input logic [2:0] l, input string t);
    @(posedge clk); #2;
    push(p, l, t);
    @(negedge clk); #1;
  endtask

  task automatic cycle(); @(negedge clk); #1; endtask

  task automatic setLines(input logic [7:0] v); reqLevel = v; cycle(); endtask
  task automatic wrTrig(input logic [7:0] v); trigData = v; trigWe = 1; cycle(); trigWe = 0; endtask
  task automatic wrMask(input logic [7:0] v); maskData = v; maskWe = 1; cycle(); maskWe = 0; endtask
  task automatic wrIsr(input logic [7:0] v);  isrData = v;  isrWe = 1;  cycle(); isrWe = 0;  endtask
  task automatic wrBase(input logic [2:0] v); baseData = v; baseWe = 1; cycle(); baseWe = 0; endtask
  task automatic ack(input logic [2:0] l);   ackLine = l;  ackValid = 1; cycle(); ackValid = 0; endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; rst = 0;
    push(0, 0, "R9 reset state");
    check(0, 0, "R9 idle after reset");

    // Edge capture
    setLines(8'h08); check(1, 3, "R2 rising edge line3");
    setLines(8'h00); check(1, 3, "R3 edge held after fall");
    ack(3);          check(0, 0, "R3 ack clears edge, sets in-service");
    wrIsr(8'h00);
    setLines(8'h10); check(1, 4, "R2 rising edge line4");
    ack(4);          check(0, 0, "R2 held-high line not re-requested");
    wrIsr(8'h00);    check(0, 0, "R2 still no request while high");
    setLines(8'h00);

    // Level capture
    wrTrig(8'h01);
    setLines(8'h01); check(1, 0, "R1 level high sets request");
    setLines(8'h00); check(0, 0, "R1 level low clears request");
    wrTrig(8'h00);

    // Mask and latency
    wrMask(8'h20);
    setLines(8'h20); check(0, 0, "R5 masked request hidden");
    wrMask(8'h00);   push(0, 0, "R8 output one edge late");
    check(1, 5, "R5 unmask reveals request");
    ack(5); wrIsr(8'h00); setLines(8'h00);

    // Rotation
    setLines(8'h42); check(1, 1, "R4 base0 line1 beats line6");
    setLines(8'h00);
    wrBase(3'd5);    check(1, 6, "R4 base5 picks line6");
    wrBase(3'd2);    check(1, 6, "R4 base2 picks line6");
    wrBase(3'd7);    check(1, 1, "R4 base7 picks line1");
    wrBase(3'd0);

    // In-service comparison
    wrIsr(8'h02);    check(0, 0, "R6 equal priority blocked");
    wrIsr(8'h01);    check(0, 0, "R6 higher in-service blocks");
    wrIsr(8'h04);    check(1, 1, "R6 lower in-service allows");
    wrIsr(8'h80);    check(1, 1, "R6 lowest in-service allows");

    // Special nesting
    wrMask(8'h02); wrIsr(8'h04);
    check(0, 0, "R7 cascade in-service counted without nesting");
    cascadeLine = 3'd2; nestEn = 1;
    check(1, 6, "R7 cascade in-service excluded");
    cascadeLine = 3'd3;
    check(0, 0, "R7 only cascade line excluded");
    nestEn = 0;

    // Reset clears registers
    wrMask(8'h01); wrIsr(8'h01); wrBase(3'd4);
    rst = 1; cycle(); cycle(); rst = 0;
    push(0, 0, "R9 reset clears outputs");
    setLines(8'h01); check(1, 0, "R9 mask, in-service, base cleared");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule